// File: doc/BRIEF.md
# Byte-Wide Boot Loader for Program RAM

This block fills internal program RAM from an external memory that is eight bits wide. It reads one byte at a time over an external memory port: a 16-bit byte address, an active-low read strobe, an address-drive enable and an 8-bit data input. It builds 24-bit instructions from those bytes and writes each finished instruction to program RAM.

The external memory holds eight pages of 8 KB. Byte offset 0 of a page is a length byte. After it, every group of four bytes holds one instruction in three bytes and one skipped filler byte. A load starts in one of two ways. The first is the first clock after reset, when both mode straps read 0. The second is a one-cycle software trigger while the block is idle. The page comes from a 3-bit select input, and the number of strobe wait cycles comes from a 3-bit setting. Both are captured when the load starts. When the last instruction has been written, a one-cycle done pulse is raised.

Top module: `eprom_boot_loader`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `mem_rd_n` is 1, `mem_addr_en`, `pm_we`, `busy` and `done` are 0.
- R2: If `strap_a` and `strap_b` both read 0 at the first clock edge after reset is released, a load starts at that edge. If either strap reads 1, no load starts and the outputs stay idle.
- R3: A `sw_start` pulse sampled while `busy` is 0 starts a load, and `busy` is 1 from the next cycle until the done cycle, inclusive. A `sw_start` sampled while `busy` is 1 has no effect.
- R4: The first read of a load uses offset 0. Every read address is the page number in bits 15:13 and the byte offset in bits 12:0.
- R5: Instruction n is built from offsets 4n+1, 4n+2 and 4n+3, with the first byte in bits 23:16 and the last in bits 7:0. Offsets that are multiples of 4, other than offset 0, are never read.
- R6: With length byte L, exactly min((L+1)×8, 2048) instructions are written, to `pm_addr` 0, 1, 2, … in order.
- R7: For wait setting W, each read holds `mem_rd_n` low and `mem_addr_en` high for W+1 cycles with a steady address. One cycle with the strobe high and the address not driven follows each read.
- R8: `pm_we` is high for one cycle: the cycle right after the third byte of an instruction is sampled. The strobe is high in that cycle.
- R9: `done` is high for exactly the one cycle after the last write. The block is then idle.
- R10: Changes to `page_sel` and `wait_cfg` after a load has started do not affect that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_a | input | 1 | Mode strap A; a load starts after reset when both straps are 0 |
| strap_b | input | 1 | Mode strap B |
| sw_start | input | 1 | Software trigger pulse |
| page_sel | input | 3 | Page to load, captured at start |
| wait_cfg | input | 3 | Number of extra strobe cycles per read, captured at start |
| mem_data | input | 8 | Byte from external memory |
| mem_addr | output | 16 | External byte address {page, offset}; 0 when not driven |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_addr_en | output | 1 | High while the address should drive the bus; low means tri-stated |
| pm_we | output | 1 | Program RAM write strobe |
| pm_addr | output | 11 | Program RAM word address |
| pm_wdata | output | 24 | Instruction to write |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
After a trigger edge, the first read strobe appears in the next cycle. Each byte is sampled at the edge that ends its W+1 low cycles. The write of a finished instruction falls in the strobe-high cycle that follows the third byte, and `done` comes one cycle after the last write. For every load, the bench builds a per-cycle list of expected outputs and checks one entry on each falling edge. The first entry applies to the cycle that follows the trigger edge, so every cycle of the strobe, address, write and done pins is checked where it is due. An empty list means the outputs must be idle, and that is how the ignored trigger, the missing strap start and the input changes made during a load are checked.

// File: rtl/eprom_boot_pkg.sv
`timescale 1ns/1ps
// Shared constants and the sequencer state type for the byte-wide boot loader.
package eprom_boot_pkg;
    localparam int BOOT_PAGE_W      = 3;
    localparam int BOOT_OFF_W       = 13;
    localparam int BOOT_BYTE_W      = 8;
    localparam int BOOT_INSTR_BYTES = 3;
    localparam int BOOT_PM_AW       = 11;
    localparam int BOOT_WAIT_W      = 3;
    localparam int BOOT_MAX_INSTR   = 2048;
    localparam int BOOT_LEN_LOG2    = 3;   // instructions per length unit = 2**3

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_GAP  = 2'd2,
        ST_DONE = 2'd3
    } boot_state_t;
endpackage

// File: rtl/boot_rd_timer.sv
`timescale 1ns/1ps
// Read strobe timer. It counts the cycles of one read access and flags the
// cycle in which the data byte is sampled.
// Assumes: run stays high for one whole access. limit must not change while
// run is high.
module boot_rd_timer #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WAIT_W-1:0] limit,
    output logic              last
);
    logic [WAIT_W-1:0] cnt_q;

    assign last = run && (cnt_q == limit);

    // Count the strobe cycles; clear between accesses.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_count_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= limit));
endmodule

// File: rtl/boot_packer.sv
`timescale 1ns/1ps
// Instruction packer. It shifts bytes in with the first byte ending up in the
// most significant position, and flags the shift that completes a word.
// Assumes: a load always ends on a full word, so the lane index is 0 at each
// start.
module boot_packer #(
    parameter int BYTE_W      = 8,
    parameter int INSTR_BYTES = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_en,
    input  logic [BYTE_W-1:0]             din,
    output logic [BYTE_W*INSTR_BYTES-1:0] word,
    output logic                          word_full
);
    localparam int WORD_W = BYTE_W * INSTR_BYTES;
    localparam int IDX_W  = (INSTR_BYTES > 1) ? $clog2(INSTR_BYTES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(INSTR_BYTES - 1);

    logic [IDX_W-1:0] idx_q;

    assign word_full = shift_en && (idx_q == IDX_LAST);

    // Track which byte lane the next byte fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (shift_en) begin
            idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end
    end

    // Shift the new byte into the low end of the word.
    generate
        if (INSTR_BYTES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word <= '0;
                end else if (shift_en) begin
                    word <= {word[WORD_W-BYTE_W-1:0], din};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word <= '0;
                end else if (shift_en) begin
                    word <= din;
                end
            end
        end
    endgenerate

    p_lane_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_LAST);
endmodule

// File: rtl/boot_ctrl.sv
`timescale 1ns/1ps
// Boot sequencer. It starts a load from the straps after reset or from a
// software trigger. It reads the length byte, then steps through the page
// in a stride of four, skipping the filler bytes, and writes each finished
// instruction in the strobe-high cycle that follows its last byte.
// Assumes: the stride is four bytes, so filler offsets have low bits 00.
module boot_ctrl
    import eprom_boot_pkg::*;
#(
    parameter int PAGE_W    = 3,
    parameter int OFF_W     = 13,
    parameter int BYTE_W    = 8,
    parameter int PM_AW     = 11,
    parameter int WAIT_W    = 3,
    parameter int MAX_INSTR = 2048,
    parameter int LEN_LOG2  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strap_a,
    input  logic                     strap_b,
    input  logic                     sw_start,
    input  logic [PAGE_W-1:0]        page_sel,
    input  logic [WAIT_W-1:0]        wait_cfg,
    input  logic [BYTE_W-1:0]        rd_data,
    input  logic                     rd_last,
    input  logic                     word_full,
    output logic                     run_read,
    output logic [WAIT_W-1:0]        wait_lim,
    output logic                     shift_en,
    output logic [PAGE_W+OFF_W-1:0]  mem_addr,
    output logic                     mem_rd_n,
    output logic                     mem_addr_en,
    output logic                     pm_we,
    output logic [PM_AW-1:0]         pm_addr,
    output logic                     busy,
    output logic                     done
);
    localparam int CNT_W = PM_AW + 1;
    localparam int CALC_W = CNT_W + 1;

    boot_state_t       state_q;
    logic              armed_q;
    logic              len_phase_q;
    logic              wr_due_q;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  off_q;
    logic [CNT_W-1:0]  instr_q;
    logic [CNT_W-1:0]  total_q;
    logic [CALC_W-1:0] total_calc;
    logic [CNT_W-1:0]  total_d;
    logic              start_req;

    // Turn the length byte into an instruction count, capped at MAX_INSTR.
    always_comb begin
        total_calc = (CALC_W'(rd_data) + 1'b1) << LEN_LOG2;
        total_d    = (total_calc > CALC_W'(MAX_INSTR)) ? CNT_W'(MAX_INSTR)
                                                      : total_calc[CNT_W-1:0];
    end

    assign start_req = (armed_q && !strap_a && !strap_b) || sw_start;

    // Sequence the reads, byte packing and writes of one load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            armed_q     <= 1'b1;
            len_phase_q <= 1'b0;
            wr_due_q    <= 1'b0;
            page_q      <= '0;
            wait_lim    <= '0;
            off_q       <= '0;
            instr_q     <= '0;
            total_q     <= '0;
        end else begin
            armed_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        page_q      <= page_sel;
                        wait_lim    <= wait_cfg;
                        off_q       <= '0;
                        instr_q     <= '0;
                        len_phase_q <= 1'b1;
                        wr_due_q    <= 1'b0;
                        state_q     <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (rd_last) begin
                        if (len_phase_q) begin
                            total_q <= total_d;
                        end
                        wr_due_q <= !len_phase_q && word_full;
                        state_q  <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    len_phase_q <= 1'b0;
                    wr_due_q    <= 1'b0;
                    off_q       <= off_q + ((off_q[1:0] == 2'd3) ? OFF_W'(2) : OFF_W'(1));
                    if (wr_due_q) begin
                        instr_q <= instr_q + 1'b1;
                    end
                    state_q <= (wr_due_q && (instr_q == total_q - 1'b1)) ? ST_DONE : ST_READ;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign run_read    = (state_q == ST_READ);
    assign shift_en    = run_read && rd_last && !len_phase_q;
    assign mem_rd_n    = !run_read;
    assign mem_addr_en = run_read;
    assign mem_addr    = run_read ? {page_q, off_q} : '0;
    assign pm_we       = (state_q == ST_GAP) && wr_due_q;
    assign pm_addr     = instr_q[PM_AW-1:0];
    assign busy        = (state_q != ST_IDLE);
    assign done        = (state_q == ST_DONE);

    p_addr_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n && $past(!mem_rd_n)) |-> $stable(mem_addr));
    p_no_filler_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n && !len_phase_q) |-> (mem_addr[1:0] != 2'd0));
    p_write_bus_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pm_we |-> mem_rd_n);
    p_write_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pm_we |-> (CNT_W'(pm_addr) < total_q));
    p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pm_we));
endmodule

// File: rtl/eprom_boot_loader.sv
`timescale 1ns/1ps
// Byte-wide boot loader top. It ties the sequencer, the strobe timer and the
// instruction packer together.
// Assumes: mem_data is valid while the strobe is low and the address is held.
module eprom_boot_loader
    import eprom_boot_pkg::*;
#(
    parameter int PAGE_W      = BOOT_PAGE_W,
    parameter int OFF_W       = BOOT_OFF_W,
    parameter int BYTE_W      = BOOT_BYTE_W,
    parameter int INSTR_BYTES = BOOT_INSTR_BYTES,
    parameter int PM_AW       = BOOT_PM_AW,
    parameter int WAIT_W      = BOOT_WAIT_W,
    parameter int MAX_INSTR   = BOOT_MAX_INSTR,
    parameter int LEN_LOG2    = BOOT_LEN_LOG2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          strap_a,
    input  logic                          strap_b,
    input  logic                          sw_start,
    input  logic [PAGE_W-1:0]             page_sel,
    input  logic [WAIT_W-1:0]             wait_cfg,
    input  logic [BYTE_W-1:0]             mem_data,
    output logic [PAGE_W+OFF_W-1:0]       mem_addr,
    output logic                          mem_rd_n,
    output logic                          mem_addr_en,
    output logic                          pm_we,
    output logic [PM_AW-1:0]              pm_addr,
    output logic [BYTE_W*INSTR_BYTES-1:0] pm_wdata,
    output logic                          busy,
    output logic                          done
);
    logic              run_read;
    logic              rd_last;
    logic              shift_en;
    logic              word_full;
    logic [WAIT_W-1:0] wait_lim;

    boot_ctrl #(
        .PAGE_W(PAGE_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W), .PM_AW(PM_AW),
        .WAIT_W(WAIT_W), .MAX_INSTR(MAX_INSTR), .LEN_LOG2(LEN_LOG2)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b(strap_b),
        .sw_start(sw_start), .page_sel(page_sel), .wait_cfg(wait_cfg),
        .rd_data(mem_data), .rd_last(rd_last), .word_full(word_full),
        .run_read(run_read), .wait_lim(wait_lim), .shift_en(shift_en),
        .mem_addr(mem_addr), .mem_rd_n(mem_rd_n), .mem_addr_en(mem_addr_en),
        .pm_we(pm_we), .pm_addr(pm_addr), .busy(busy), .done(done)
    );

    boot_rd_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run_read), .limit(wait_lim), .last(rd_last)
    );

    boot_packer #(.BYTE_W(BYTE_W), .INSTR_BYTES(INSTR_BYTES)) u_packer (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(mem_data),
        .word(pm_wdata), .word_full(word_full)
    );
endmodule

// File: tb/tb_eprom_boot_loader.sv
`timescale 1ns/1ps
module tb_eprom_boot_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_a = 1'b1;
    logic        strap_b = 1'b1;
    logic        sw_start = 1'b0;
    logic [2:0]  page_sel = 3'd0;
    logic [2:0]  wait_cfg = 3'd0;
    logic [7:0]  mem_data;
    logic [15:0] mem_addr;
    logic        mem_rd_n, mem_addr_en, pm_we, busy, done;
    logic [10:0] pm_addr;
    logic [23:0] pm_wdata;

    logic [7:0]  len_tab [8];
    logic [54:0] expq [$];   // {busy,done,we,rd_n,addr16,wa11,wd24}
    int checks = 0;
    int errors = 0;
    int writes_seen = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    eprom_boot_loader dut (
        .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b(strap_b),
        .sw_start(sw_start), .page_sel(page_sel), .wait_cfg(wait_cfg),
        .mem_data(mem_data), .mem_addr(mem_addr), .mem_rd_n(mem_rd_n),
        .mem_addr_en(mem_addr_en), .pm_we(pm_we), .pm_addr(pm_addr),
        .pm_wdata(pm_wdata), .busy(busy), .done(done)
    );

    // External memory model: offset 0 holds the page length, other bytes a pattern.
    function automatic logic [7:0] pat(input logic [15:0] a);
        logic [15:0] t;
        t = a * 16'd7 + {13'd0, a[15:13]} * 16'd13 + 16'h3C;
        return t[7:0];
    endfunction
    assign mem_data = (mem_addr[12:0] == 13'd0) ? len_tab[mem_addr[15:13]] : pat(mem_addr);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_sim();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic push(input bit b, input bit d, input bit we, input bit rdn,
                        input logic [15:0] a, input logic [10:0] wa, input logic [23:0] wd);
        expq.push_back({b, d, we, rdn, a, wa, wd});
    endtask

    // Queue the expected outputs of one load, one entry per cycle after the start edge.
    task automatic build(input int page, input int len, input int w);
        int total;
        int off;
        logic [23:0] word;
        total = (len + 1) * 8;
        if (total > 2048) total = 2048;
        for (int i = 0; i <= w; i++) push(1, 0, 0, 0, {page[2:0], 13'd0}, 0, 0);
        push(1, 0, 0, 1, 0, 0, 0);
        for (int n = 0; n < total; n++) begin
            word = 0;
            for (int k = 1; k <= 3; k++) begin
                off = 4 * n + k;
                word = {word[15:0], pat({page[2:0], off[12:0]})};
                for (int i = 0; i <= w; i++) push(1, 0, 0, 0, {page[2:0], off[12:0]}, 0, 0);
                if (k == 3) push(1, 0, 1, 1, 0, n[10:0], word);
                else        push(1, 0, 0, 1, 0, 0, 0);
            end
        end
        push(1, 1, 0, 1, 0, 0, 0);
    endtask

    // Compare one cycle of outputs with the next expected entry (idle when empty).
    task automatic tick();
        logic [54:0] e;
        @(negedge clk);
        e = (expq.size() > 0) ? expq.pop_front() : {3'b000, 1'b1, 51'd0};
        chk(busy == e[54], "R3 busy", busy, e[54]);
        chk(done == e[53], "R9 done", done, e[53]);
        chk(pm_we == e[52], "R8 pm_we", pm_we, e[52]);
        chk(mem_rd_n == e[51], "R7 mem_rd_n", mem_rd_n, e[51]);
        chk(mem_addr_en == !e[51], "R7 mem_addr_en", mem_addr_en, !e[51]);
        if (!e[51]) chk(mem_addr == e[50:35], "R4 R5 mem_addr", mem_addr, e[50:35]);
        if (e[52]) begin
            writes_seen++;
            chk(pm_addr == e[34:24], "R6 pm_addr", pm_addr, e[34:24]);
            chk(pm_wdata == e[23:0], "R5 pm_wdata", pm_wdata, e[23:0]);
        end
    endtask

    // Start a load by software; optionally disturb inputs during it (R3, R10).
    task automatic sw_load(input int page, input int len, input int w, input bit disturb);
        int exp_writes;
        int cyc;
        exp_writes = ((len + 1) * 8 > 2048) ? 2048 : (len + 1) * 8;
        writes_seen = 0;
        len_tab[page] = len[7:0];
        page_sel = page[2:0];
        wait_cfg = w[2:0];
        sw_start = 1'b1;
        build(page, len, w);
        tick();
        sw_start = 1'b0;
        cyc = 0;
        while (expq.size() > 0) begin
            if (disturb && cyc == 5) begin
                sw_start = 1'b1;              // r3_ ignored while busy
                page_sel = page_sel + 3'd1;   // r10_ no effect
                wait_cfg = wait_cfg + 3'd2;
            end
            tick();
            sw_start = 1'b0;
            cyc++;
        end
        for (int i = 0; i < 4; i++) tick();
        chk(writes_seen == exp_writes, "R6 write count", writes_seen, exp_writes);
    endtask

    initial begin
        for (int p = 0; p < 8; p++) len_tab[p] = 8'd0;
        // R1: reset state and straps not both low (R2 negative).
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b1;
        tick();
        chk(mem_rd_n == 1'b1 && !mem_addr_en && !pm_we && !busy && !done, "R1 reset idle",
            {mem_rd_n, mem_addr_en, pm_we, busy, done}, 5'b10000);
        for (int i = 0; i < 20; i++) tick();   // R2: no load with strap_a high

        sw_load(2, 0, 0, 1'b1);
        sw_load(5, 1, 7, 1'b0);
        sw_load(0, 0, 3, 1'b1);
        sw_load(7, 255, 0, 1'b0);               // R6 largest count

        // R2: strap start after reset with both straps low.
        rst_n = 1'b0;
        strap_a = 1'b0;
        strap_b = 1'b0;
        page_sel = 3'd3;
        wait_cfg = 3'd2;
        len_tab[3] = 8'd2;
        tick();
        tick();
        rst_n = 1'b1;
        writes_seen = 0;
        build(3, 2, 2);
        while (expq.size() > 0) tick();
        for (int i = 0; i < 4; i++) tick();
        chk(writes_seen == 24, "R2 strap load count", writes_seen, 24);
        finish_sim();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_sim();
    end
endmodule